// File: doc/BRIEF.md
# Multi-Mode Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync, display-enable window and a per-pixel beat strobe for a 320x240 TFT panel fed through a parallel pixel port. All timing is counted in port clock ticks. A two-bit mode selects how many port clocks carry one pixel: a 16-bit port at one clock per pixel, an 8-bit port carrying RGB565 over two clocks, or an 8-bit port carrying RGB888 over three clocks. Every horizontal quantity and the vertical pulse width scale with that clock count, and the first-pixel position also adds a small per-mode pipeline correction.

The mode is captured in the cycle the enable is first seen high; later changes on the mode pins are ignored until the block is disabled and enabled again. An illegal mode prevents the start and raises an error flag. The block also exposes its tick-in-line and line counters so a downstream fetch engine can follow the raster. Frame geometry (active pixels, line period, lead-in, blanking lines, pulse widths) is set by parameters; the defaults give the 320x240 panel with a 336-pixel line and 4 blanking lines.

Top module: `lcd_sync_gen`

## Requirements
- R1: Mode encoding on `mode_i`: 0 = one clock per pixel with correction 0, 1 = two clocks per pixel with correction 3, 2 = three clocks per pixel with correction 5; call the clock count C.
- R2: Mode 3 is illegal: when enable is first sampled high with mode 3 the block does not run (`run_o` low, syncs high, `de_o` low) and `mode_err_o` goes high; the flag clears at the next start with a legal mode.
- R3: While running, `tick_o` counts 0 to 336·C−1 and wraps, `line_o` advances at each wrap and wraps from 243 to 0 (244 lines per frame, so the frame lasts 336·C·244 ticks).
- R4: `hsync_n_o` is low exactly on ticks 0 to 2·C−1 of every line.
- R5: `vsync_n_o` is low exactly on ticks 0 to 2·C−1 of line 0, so it falls on the same tick as `hsync_n_o`.
- R6: `de_o` is high exactly on lines 2 to 241 for ticks from S = 7·C + correction up to S + 320·C − 1, leaving two blank lines before and two after the visible rows.
- R7: `pix_stb_o` is high exactly on the ticks S + k·C inside the `de_o` window, one per pixel.
- R8: When enable is sampled low, from the next cycle `run_o` is low, both counters read 0, both syncs are high and `de_o` and `pix_stb_o` are low.
- R9: The first cycle after enable is sampled high shows line 0, tick 0 with both syncs low; the mode used is the one present at that sample, and mode changes while running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; rising use captures the mode |
| mode_i | input | 2 | Pixel packing mode (see R1, R2) |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Display-enable window |
| pix_stb_o | output | 1 | First tick of each pixel in the window |
| tick_o | output | TICK_W | Tick position within the line |
| line_o | output | LINE_W | Line position within the frame |
| run_o | output | 1 | Generator is running |
| mode_err_o | output | 1 | Last start attempt used an illegal mode |

## Verification
Every output is decoded from registers updated on the rising edge, so a stimulus sampled at edge k shows its effect in the cycle right after edge k: the start shows line 0 tick 0 one cycle after enable is sampled, and the stop shows cleared counters and idle syncs one cycle after enable drops. The bench drives inputs and samples outputs on the falling edge, comparing after each rising edge against a model that derives tick and line from the number of cycles since the start by division and remainder. A shrunken geometry lets every legal mode run a whole frame plus one line with every output compared on every cycle, including a mode-pin change mid-run, the illegal mode and a stop-restart.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    PM_WIDE16    = 2'd0,
    PM_NARROW565 = 2'd1,
    PM_NARROW888 = 2'd2,
    PM_BAD       = 2'd3
  } port_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } run_state_e;

  function automatic logic mode_legal(input logic [1:0] m);
    return m != PM_BAD;
  endfunction

  function automatic logic [1:0] mode_cpp(input logic [1:0] m);
    case (m)
      PM_WIDE16:    return 2'd1;
      PM_NARROW565: return 2'd2;
      PM_NARROW888: return 2'd3;
      default:      return 2'd1;
    endcase
  endfunction

  function automatic logic [2:0] mode_corr(input logic [1:0] m);
    case (m)
      PM_NARROW565: return 3'd3;
      PM_NARROW888: return 3'd5;
      default:      return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/lcd_run_ctrl.sv
module lcd_run_ctrl
  import lcd_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output logic       run_o,
  output logic [1:0] mode_q_o,
  output logic       err_o
);

  run_state_e st_q;
  logic [1:0] mode_q;
  logic       err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= PM_WIDE16;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (en_i) begin
            mode_q <= mode_i;
            if (mode_legal(mode_i)) begin
              st_q  <= ST_RUN;
              err_q <= 1'b0;
            end else begin
              st_q  <= ST_FAULT;
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN:   if (!en_i) st_q <= ST_IDLE;
        ST_FAULT: if (!en_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (st_q == ST_RUN);
  assign mode_q_o = mode_q;
  assign err_o    = err_q;

endmodule

// File: rtl/lcd_mode_timing.sv
module lcd_mode_timing
  import lcd_sync_pkg::*;
#(
  parameter int H_ACTIVE_PIX = 320,
  parameter int H_TOTAL_PIX  = 336,
  parameter int H_SYNC_PIX   = 2,
  parameter int H_LEAD_PIX   = 7,
  parameter int V_SYNC_PIX   = 2,
  parameter int TICK_W       = 10
) (
  input  logic [1:0]        mode_i,
  output logic [1:0]        cpp_o,
  output logic [TICK_W-1:0] h_period_o,
  output logic [TICK_W-1:0] h_pulse_o,
  output logic [TICK_W-1:0] h_start_o,
  output logic [TICK_W-1:0] h_end_o,
  output logic [TICK_W-1:0] v_pulse_o
);

  localparam logic [TICK_W-1:0] P_TOTAL = TICK_W'(H_TOTAL_PIX);
  localparam logic [TICK_W-1:0] P_HSYNC = TICK_W'(H_SYNC_PIX);
  localparam logic [TICK_W-1:0] P_LEAD  = TICK_W'(H_LEAD_PIX);
  localparam logic [TICK_W-1:0] P_ACT   = TICK_W'(H_ACTIVE_PIX);
  localparam logic [TICK_W-1:0] P_VSYNC = TICK_W'(V_SYNC_PIX);

  function automatic logic [TICK_W-1:0] scale(input logic [TICK_W-1:0] x,
                                              input logic [1:0] k);
    case (k)
      2'd2:    return x << 1;
      2'd3:    return (x << 1) + x;
      default: return x;
    endcase
  endfunction

  logic [1:0]        cpp;
  logic [TICK_W-1:0] start;

  always_comb begin
    cpp        = mode_cpp(mode_i);
    start      = scale(P_LEAD, cpp) + TICK_W'(mode_corr(mode_i));
    cpp_o      = cpp;
    h_period_o = scale(P_TOTAL, cpp);
    h_pulse_o  = scale(P_HSYNC, cpp);
    h_start_o  = start;
    h_end_o    = start + scale(P_ACT, cpp);
    v_pulse_o  = scale(P_VSYNC, cpp);
  end

endmodule

// File: rtl/lcd_raster_cnt.sv
module lcd_raster_cnt #(
  parameter int TICK_W  = 10,
  parameter int LINE_W  = 8,
  parameter int V_LINES = 244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [TICK_W-1:0] h_period_i,
  input  logic [TICK_W-1:0] h_start_i,
  input  logic [1:0]        cpp_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [LINE_W-1:0] line_o,
  output logic [1:0]        phase_o
);

  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_LINES - 1);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [1:0]        phase_q, phase_d;
  logic              eol;

  always_comb begin
    eol     = (tick_q == h_period_i - TICK_W'(1));
    tick_d  = '0;
    line_d  = '0;
    phase_d = '0;
    if (adv_i) begin
      if (eol) begin
        tick_d = '0;
        line_d = (line_q == LINE_LAST) ? '0 : line_q + LINE_W'(1);
      end else begin
        tick_d = tick_q + TICK_W'(1);
        line_d = line_q;
      end
      if (tick_d == h_start_i)             phase_d = 2'd0;
      else if (phase_q == cpp_i - 2'd1)    phase_d = 2'd0;
      else                                 phase_d = phase_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= '0;
      line_q  <= '0;
      phase_q <= '0;
    end else begin
      tick_q  <= tick_d;
      line_q  <= line_d;
      phase_q <= phase_d;
    end
  end

  assign tick_o  = tick_q;
  assign line_o  = line_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode #(
  parameter int TICK_W = 10,
  parameter int LINE_W = 8,
  parameter int V_TOP  = 2,
  parameter int V_END  = 242
) (
  input  logic              run_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [1:0]        phase_i,
  input  logic [TICK_W-1:0] h_pulse_i,
  input  logic [TICK_W-1:0] h_start_i,
  input  logic [TICK_W-1:0] h_end_i,
  input  logic [TICK_W-1:0] v_pulse_i,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              de_o,
  output logic              stb_o
);

  localparam logic [LINE_W-1:0] L_TOP = LINE_W'(V_TOP);
  localparam logic [LINE_W-1:0] L_END = LINE_W'(V_END);

  logic vis_line, in_cols;

  always_comb begin
    vis_line  = (line_i >= L_TOP) && (line_i < L_END);
    in_cols   = (tick_i >= h_start_i) && (tick_i < h_end_i);
    hsync_n_o = !(run_i && (tick_i < h_pulse_i));
    vsync_n_o = !(run_i && (line_i == '0) && (tick_i < v_pulse_i));
    de_o      = run_i && vis_line && in_cols;
    stb_o     = de_o && (phase_i == 2'd0);
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int H_ACTIVE_PIX = 320,
  parameter int H_TOTAL_PIX  = 336,
  parameter int H_SYNC_PIX   = 2,
  parameter int H_LEAD_PIX   = 7,
  parameter int V_ACTIVE     = 240,
  parameter int V_BLANK      = 4,
  parameter int V_SYNC_PIX   = 2,
  localparam int V_LINES     = V_ACTIVE + V_BLANK,
  localparam int TICK_W      = $clog2(3 * H_TOTAL_PIX + 1),
  localparam int LINE_W      = $clog2(V_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              de_o,
  output logic              pix_stb_o,
  output logic [TICK_W-1:0] tick_o,
  output logic [LINE_W-1:0] line_o,
  output logic              run_o,
  output logic              mode_err_o
);

  localparam int V_TOP = V_BLANK / 2;
  localparam int V_END = V_TOP + V_ACTIVE;

  logic              run, adv;
  logic [1:0]        mode_q, cpp, phase;
  logic [TICK_W-1:0] h_period, h_pulse, h_start, h_end, v_pulse;

  lcd_run_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .mode_i   (mode_i),
    .run_o    (run),
    .mode_q_o (mode_q),
    .err_o    (mode_err_o)
  );

  lcd_mode_timing #(
    .H_ACTIVE_PIX (H_ACTIVE_PIX),
    .H_TOTAL_PIX  (H_TOTAL_PIX),
    .H_SYNC_PIX   (H_SYNC_PIX),
    .H_LEAD_PIX   (H_LEAD_PIX),
    .V_SYNC_PIX   (V_SYNC_PIX),
    .TICK_W       (TICK_W)
  ) u_timing (
    .mode_i     (mode_q),
    .cpp_o      (cpp),
    .h_period_o (h_period),
    .h_pulse_o  (h_pulse),
    .h_start_o  (h_start),
    .h_end_o    (h_end),
    .v_pulse_o  (v_pulse)
  );

  assign adv = run & en_i;

  lcd_raster_cnt #(
    .TICK_W  (TICK_W),
    .LINE_W  (LINE_W),
    .V_LINES (V_LINES)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv),
    .h_period_i (h_period),
    .h_start_i  (h_start),
    .cpp_i      (cpp),
    .tick_o     (tick_o),
    .line_o     (line_o),
    .phase_o    (phase)
  );

  lcd_sync_decode #(
    .TICK_W (TICK_W),
    .LINE_W (LINE_W),
    .V_TOP  (V_TOP),
    .V_END  (V_END)
  ) u_dec (
    .run_i     (run),
    .tick_i    (tick_o),
    .line_i    (line_o),
    .phase_i   (phase),
    .h_pulse_i (h_pulse),
    .h_start_i (h_start),
    .h_end_i   (h_end),
    .v_pulse_i (v_pulse),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .de_o      (de_o),
    .stb_o     (pix_stb_o)
  );

  assign run_o = run;

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int TICK_W = 10,
  parameter int LINE_W = 8,
  parameter int V_TOP  = 2,
  parameter int V_END  = 242
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [1:0]        mode_q,
  input logic              run_o,
  input logic              hsync_n_o,
  input logic              vsync_n_o,
  input logic              de_o,
  input logic              pix_stb_o,
  input logic              mode_err_o,
  input logic [TICK_W-1:0] tick_o,
  input logic [LINE_W-1:0] line_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (hsync_n_o && vsync_n_o && !de_o && !pix_stb_o)); // R8

  AST_ERR_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> !run_o); // R2

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> (tick_o == '0 && line_o == '0 && !hsync_n_o && !vsync_n_o)); // R9

  AST_VS_WITH_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n_o |-> !hsync_n_o); // R5

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && en_i) |=> (tick_o == $past(tick_o) + TICK_W'(1) || tick_o == '0)); // R3

  AST_STB_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb_o |-> de_o); // R7

  AST_DE_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (line_o >= LINE_W'(V_TOP) && line_o < LINE_W'(V_END))); // R6

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && en_i) |=> $stable(mode_q)); // R9

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(
  .TICK_W (TICK_W),
  .LINE_W (LINE_W),
  .V_TOP  (V_BLANK / 2),
  .V_END  (V_BLANK / 2 + V_ACTIVE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .mode_q     (mode_q),
  .run_o      (run_o),
  .hsync_n_o  (hsync_n_o),
  .vsync_n_o  (vsync_n_o),
  .de_o       (de_o),
  .pix_stb_o  (pix_stb_o),
  .mode_err_o (mode_err_o),
  .tick_o     (tick_o),
  .line_o     (line_o)
);

// File: tb/lcd_sync_gen_bench.sv
`timescale 1ns/1ps
module lcd_sync_gen_bench;

  localparam int HA = 8;
  localparam int HT = 18;
  localparam int HS = 2;
  localparam int HL = 7;
  localparam int VA = 6;
  localparam int VB = 4;
  localparam int VS = 2;
  localparam int VL = VA + VB;
  localparam int TW = $clog2(3 * HT + 1);
  localparam int LW = $clog2(VL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          hsync_n_o, vsync_n_o, de_o, pix_stb_o, run_o, mode_err_o;
  logic [TW-1:0] tick_o;
  logic [LW-1:0] line_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_sync_gen #(
    .H_ACTIVE_PIX (HA), .H_TOTAL_PIX (HT), .H_SYNC_PIX (HS),
    .H_LEAD_PIX (HL), .V_ACTIVE (VA), .V_BLANK (VB), .V_SYNC_PIX (VS)
  ) u_lcd_sync_gen (
    .clk (clk), .rst_n (rst_n), .en_i (en_i), .mode_i (mode_i),
    .hsync_n_o (hsync_n_o), .vsync_n_o (vsync_n_o), .de_o (de_o),
    .pix_stb_o (pix_stb_o), .tick_o (tick_o), .line_o (line_o),
    .run_o (run_o), .mode_err_o (mode_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " run"}, int'(run_o), 0);
    chk({req, " tick"}, int'(tick_o), 0);
    chk({req, " line"}, int'(line_o), 0);
    chk({req, " hsync_n"}, int'(hsync_n_o), 1);
    chk({req, " vsync_n"}, int'(vsync_n_o), 1);
    chk({req, " de"}, int'(de_o), 0);
    chk({req, " stb"}, int'(pix_stb_o), 0);
  endtask

  // Expected raster for mode m, n cycles after the first running cycle (R1)
  task automatic chk_raster(input int m, input int n);
    int cpp, corr, hp, t, l, st, act, e_de, e_stb;
    cpp  = m + 1;
    corr = (m == 0) ? 0 : (m == 1) ? 3 : 5;
    hp   = HT * cpp;
    t    = n % hp;
    l    = (n / hp) % VL;
    st   = HL * cpp + corr;
    act  = HA * cpp;
    e_de  = (l >= VB / 2 && l < VB / 2 + VA && t >= st && t < st + act) ? 1 : 0;
    e_stb = (e_de == 1 && ((t - st) % cpp) == 0) ? 1 : 0;
    chk("R3 tick", int'(tick_o), t);
    chk("R3 line", int'(line_o), l);
    chk("R4 hsync_n", int'(hsync_n_o), (t < HS * cpp) ? 0 : 1);
    chk("R5 vsync_n", int'(vsync_n_o), (l == 0 && t < VS * cpp) ? 0 : 1);
    chk("R6 de", int'(de_o), e_de);
    chk("R7 stb", int'(pix_stb_o), e_stb);
  endtask

  // Start in mode m and compare every cycle for ncyc cycles (R9 origin)
  task automatic sweep(input int m, input int ncyc, input bit poke_mode);
    @(negedge clk);
    mode_i = 2'(m);
    en_i   = 1'b1;
    @(negedge clk);
    chk("R9 run", int'(run_o), 1);
    chk("R2 err clear", int'(mode_err_o), 0);
    for (int n = 0; n < ncyc; n++) begin
      chk_raster(m, n);
      if (poke_mode && n == 5) mode_i = 2'd0; // R9: ignored while running
      @(negedge clk);
    end
    en_i = 1'b0;
    @(negedge clk);
    chk_idle("R8 stop");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk_idle("R8 reset");
    chk("R2 reset err", int'(mode_err_o), 0);
    rst_n = 1'b1;
    // full frame plus a line in each legal mode (R1)
    for (int m = 0; m < 3; m++)
      sweep(m, HT * (m + 1) * (VL + 1), (m == 2));
    // illegal mode (R2)
    @(negedge clk);
    mode_i = 2'd3;
    en_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_idle("R2 refuse");
      chk("R2 err", int'(mode_err_o), 1);
    end
    en_i = 1'b0;
    @(negedge clk);
    chk("R2 err held", int'(mode_err_o), 1);
    // restart with a legal mode clears the flag, then stop mid-frame
    sweep(1, 3 * HT * 2 + 11, 1'b0);
    // quick restart in a different mode starts from the origin
    sweep(2, HT * 3 * 2, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule